// File: doc/BRIEF.md
# Daisy-Chain Self-Enumerating Node

Each node of a serial chain runs this identical controller. A node has an upstream line toward the head of the chain and a downstream line toward its tail. Both lines are open-drain with pull-ups, so the controller never drives a high level. Instead it asserts an output-enable that pulls the line low.

A node sleeps until its upstream line goes low. It then listens on that line for a short serial frame. The frame is a sync byte followed by an ID byte.
- A node that hears a frame becomes a slave and adopts the received ID.
- A node whose listen window runs out becomes the master and keeps the reset ID.

Either way, the node wakes its downstream neighbour with a low pulse and then sends that neighbour the next ID.

After that, each slave announces itself with a low pulse on its upstream line. It then relays low levels from its downstream line back upstream for a fixed idle period. The master counts the pulses that reach its downstream line during a counting window, and this count is the chain length. All durations are given in milliseconds, with a cycles-per-millisecond parameter, so simulations can run with shortened time.

Top module: `enn_node`

## Requirements
- R1: After reset, and for as long as the upstream line stays high, the node drives neither line low, and `done`, `is_master`, `node_id` and `slave_cnt` all read 0.
- R2: Once woken, the node receives 8N1 bytes on the upstream line (low start bit, LSB first, BAUD_DIV cycles per bit). Until it has seen the byte 0x7E, every other byte is ignored. The byte that follows 0x7E becomes `node_id`, and the node becomes a slave (`is_master` = 0).
- R3: If LISTEN_MS milliseconds pass after wake-up with no complete sync+ID frame, the node becomes the master (`is_master` = 1) and keeps the reset ID of 0.
- R4: Once its role is decided, the node drives the downstream line low for exactly WAKE_MS milliseconds and then releases it.
- R5: After a further GAP_MS milliseconds, the node sends two 8N1 bytes on the downstream line, 0x7E first and then (`node_id` + 1) mod 256. This holds for either role.
- R6: After its frame, a slave drives the upstream line low for exactly WAKE_MS milliseconds. A master never drives the upstream line.
- R7: While relaying, a slave pulls the upstream line low two cycles after its downstream line goes low, and releases it two cycles after the downstream line returns high. The slave samples the downstream line every RELAY_TICK_MS milliseconds. Relaying ends after RELAY_TICKS of those samples have found the line high.
- R8: The master counts falling edges on its downstream line for COUNT_MS milliseconds after its frame. The count never decreases and saturates at 255.
- R9: At the end, `done` rises and stays high until reset. While `done` is high, `is_master`, `node_id` and `slave_cnt` hold their values and line activity has no effect on them. A slave reports `slave_cnt` = 0. The two lines are never driven low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in | input | 1 | Level seen on the upstream line |
| dn_in | input | 1 | Level seen on the downstream line |
| up_oe | output | 1 | Pull the upstream line low |
| dn_oe | output | 1 | Pull the downstream line low |
| done | output | 1 | Enumeration finished |
| is_master | output | 1 | Node took the master role |
| node_id | output | 8 | ID this node holds |
| slave_cnt | output | 8 | Slaves counted by the master, saturating |

## Verification
The bench runs slave enumerations with random IDs, plus the ID 0xFF, which checks that the forwarded ID wraps to 0x00. In each of these runs a junk byte comes before the sync byte, which tells a receiver that waits for 0x7E apart from one that takes the first byte it sees. Master runs feed a non-sync byte and then silence. They then deliver random pulse counts, zero pulses, and 300 pulses, which separates a plain count from a saturating one. Pulses sent after `done` check that the results are frozen. In relay, the bench measures the mirror latency and the time until `done`, which shows whether low ticks are left out of the idle-tick count.

// File: rtl/enn_pkg.sv
package enn_pkg;

    localparam logic [7:0] SYNC_CHAR = 8'h7E;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LISTEN, ST_WAKE, ST_GAP, ST_SYNC,
        ST_ID, ST_ANNOUNCE, ST_COUNT, ST_RELAY, ST_DONE
    } enn_state_e;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_phase_e;

    typedef struct packed {
        logic       master;
        logic [7:0] id;
        logic [7:0] count;
    } enn_result_t;

    function automatic logic [7:0] sat_inc8(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/enn_tick.sv
module enn_tick #(
    parameter int CYC_PER_MS = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    logic [W-1:0] cnt;

    assign tick = (cnt == W'(CYC_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/enn_uart_rx.sv
module enn_uart_rx
    import enn_pkg::*;
#(
    parameter int DIV = 833
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    localparam int CW = $clog2(DIV + 1);
    rx_phase_e   ph;
    logic        prev;
    logic [CW-1:0] cnt;
    logic [2:0]  bitn;
    logic [7:0]  sh;

    assign data = sh;

    always_ff @(posedge clk) begin
        valid <= 1'b0;
        if (rst) prev <= 1'b1;
        else     prev <= rxd;
        if (rst || !en) begin
            ph   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            if (rst) sh <= '0;
        end else begin
            case (ph)
                RX_IDLE: if (prev && !rxd) begin
                    ph  <= RX_START;
                    cnt <= '0;
                end
                RX_START: if (cnt == CW'(DIV / 2 - 1)) begin
                    cnt  <= '0;
                    bitn <= '0;
                    ph   <= rxd ? RX_IDLE : RX_DATA;
                end else cnt <= cnt + 1'b1;
                RX_DATA: if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                    sh  <= {rxd, sh[7:1]};
                    if (bitn == 3'd7) ph <= RX_STOP;
                    else              bitn <= bitn + 1'b1;
                end else cnt <= cnt + 1'b1;
                default: if (cnt == CW'(DIV - 1)) begin
                    cnt   <= '0;
                    valid <= rxd;
                    ph    <= RX_IDLE;
                end else cnt <= cnt + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/enn_uart_tx.sv
module enn_uart_tx #(
    parameter int DIV = 833
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] byte_in,
    output logic       txd,
    output logic       busy
);
    localparam int CW = $clog2(DIV + 1);
    logic [9:0]    fr;
    logic [CW-1:0] cnt;
    logic [3:0]    nb;

    assign txd = busy ? fr[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            fr   <= '1;
            cnt  <= '0;
            nb   <= '0;
        end else if (!busy) begin
            if (start) begin
                fr   <= {1'b1, byte_in, 1'b0};
                busy <= 1'b1;
                cnt  <= '0;
                nb   <= '0;
            end
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
            fr  <= {1'b1, fr[9:1]};
            if (nb == 4'd9) busy <= 1'b0;
            else            nb   <= nb + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/enn_node.sv
module enn_node
    import enn_pkg::*;
#(
    parameter int         CYC_PER_MS    = 8000,
    parameter int         BAUD_DIV      = 833,
    parameter int         LISTEN_MS     = 600,
    parameter int         WAKE_MS       = 50,
    parameter int         GAP_MS        = 50,
    parameter int         COUNT_MS      = 4000,
    parameter int         RELAY_TICK_MS = 15,
    parameter int         RELAY_TICKS   = 255,
    parameter logic [7:0] FIRST_ID      = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       up_in,
    input  logic       dn_in,
    output logic       up_oe,
    output logic       dn_oe,
    output logic       done,
    output logic       is_master,
    output logic [7:0] node_id,
    output logic [7:0] slave_cnt
);
    localparam int MAX_MS = (COUNT_MS > LISTEN_MS) ? COUNT_MS : LISTEN_MS;
    localparam int MW     = $clog2(MAX_MS + 1);

    enn_state_e  state_q, state_d;
    enn_result_t res;
    logic [1:0]  up_sync, dn_sync;
    logic        up_s, dn_s, dn_prev;
    logic        ent_q, chg, ms_tick, tmo, got_sync;
    logic [MW-1:0] ms_cnt, lim;
    logic [7:0]  idle_cnt;
    logic        rx_valid, txd, tx_busy, tx_start, frame_ok;
    logic [7:0]  rx_data, tx_byte;

    assign up_s = up_sync[1];
    assign dn_s = dn_sync[1];

    enn_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk(clk), .rst(rst), .clr(chg), .tick(ms_tick));

    enn_uart_rx #(.DIV(BAUD_DIV)) u_rx (
        .clk(clk), .rst(rst), .en(state_q == ST_LISTEN), .rxd(up_s),
        .valid(rx_valid), .data(rx_data));

    enn_uart_tx #(.DIV(BAUD_DIV)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .byte_in(tx_byte),
        .txd(txd), .busy(tx_busy));

    always_comb begin
        case (state_q)
            ST_LISTEN:   lim = MW'(LISTEN_MS - 1);
            ST_WAKE:     lim = MW'(WAKE_MS - 1);
            ST_GAP:      lim = MW'(GAP_MS - 1);
            ST_ANNOUNCE: lim = MW'(WAKE_MS - 1);
            ST_COUNT:    lim = MW'(COUNT_MS - 1);
            ST_RELAY:    lim = MW'(RELAY_TICK_MS - 1);
            default:     lim = '0;
        endcase
    end

    assign tmo      = ms_tick && (ms_cnt == lim);
    assign frame_ok = (state_q == ST_LISTEN) && rx_valid && got_sync;
    assign tx_start = ent_q && (state_q == ST_SYNC || state_q == ST_ID);
    assign tx_byte  = (state_q == ST_SYNC) ? SYNC_CHAR : res.id + 8'd1;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (!up_s) state_d = ST_LISTEN;
            ST_LISTEN:   if (frame_ok || tmo) state_d = ST_WAKE;
            ST_WAKE:     if (tmo) state_d = ST_GAP;
            ST_GAP:      if (tmo) state_d = ST_SYNC;
            ST_SYNC:     if (!ent_q && !tx_busy) state_d = ST_ID;
            ST_ID:       if (!ent_q && !tx_busy)
                             state_d = res.master ? ST_COUNT : ST_ANNOUNCE;
            ST_ANNOUNCE: if (tmo) state_d = ST_RELAY;
            ST_COUNT:    if (tmo) state_d = ST_DONE;
            ST_RELAY:    if (tmo && dn_s && idle_cnt == 8'(RELAY_TICKS - 1))
                             state_d = ST_DONE;
            default:     state_d = ST_DONE;
        endcase
    end

    assign chg = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ent_q    <= 1'b0;
            up_sync  <= 2'b11;
            dn_sync  <= 2'b11;
            dn_prev  <= 1'b1;
            ms_cnt   <= '0;
            got_sync <= 1'b0;
            idle_cnt <= '0;
            res      <= '{master: 1'b0, id: FIRST_ID, count: 8'd0};
        end else begin
            state_q <= state_d;
            ent_q   <= chg;
            up_sync <= {up_sync[0], up_in};
            dn_sync <= {dn_sync[0], dn_in};
            dn_prev <= dn_s;
            if (chg || tmo)   ms_cnt <= '0;
            else if (ms_tick) ms_cnt <= ms_cnt + 1'b1;
            if (state_q == ST_LISTEN) begin
                if (rx_valid) begin
                    if (!got_sync) got_sync <= (rx_data == SYNC_CHAR);
                    else           res.id   <= rx_data;
                end else if (tmo) begin
                    res.master <= 1'b1;
                end
            end
            if (state_q == ST_COUNT && dn_prev && !dn_s)
                res.count <= sat_inc8(res.count);
            if (state_q == ST_RELAY && tmo && dn_s)
                idle_cnt <= idle_cnt + 8'd1;
        end
    end

    assign dn_oe = (state_q == ST_WAKE) ||
                   ((state_q == ST_SYNC || state_q == ST_ID) && !txd);
    assign up_oe = (state_q == ST_ANNOUNCE) || (state_q == ST_RELAY && !dn_s);

    assign done      = (state_q == ST_DONE);
    assign is_master = res.master;
    assign node_id   = res.id;
    assign slave_cnt = res.count;
endmodule

// File: rtl/enn_node_chk.sv
module enn_node_chk (
    input logic       clk,
    input logic       rst,
    input logic       up_oe,
    input logic       dn_oe,
    input logic       done,
    input logic       is_master,
    input logic [7:0] node_id,
    input logic [7:0] slave_cnt
);
    assert_lines_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(up_oe && dn_oe));

    assert_done_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(is_master) && $stable(node_id) && $stable(slave_cnt));

    assert_slave_zero_count_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !is_master) |-> (slave_cnt == 8'd0));

    assert_count_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        slave_cnt >= $past(slave_cnt));

    assert_master_quiet_up_R6: assert property (@(posedge clk) disable iff (rst)
        is_master |-> !up_oe);

    assert_idle_no_role_R1: assert property (@(posedge clk) disable iff (rst)
        (!is_master && !done) |-> (slave_cnt == 8'd0));
endmodule

bind enn_node enn_node_chk u_chk (
    .clk(clk), .rst(rst), .up_oe(up_oe), .dn_oe(dn_oe), .done(done),
    .is_master(is_master), .node_id(node_id), .slave_cnt(slave_cnt));

// File: tb/enn_node_bench.sv
module enn_node_bench;
    localparam int CYC    = 2;
    localparam int DIV    = 8;
    localparam int WAKE_C = 50 * CYC;
    localparam int LIST_C = 600 * CYC;
    localparam int RELAY_C = 255 * 15 * CYC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_drv = 1'b1, dn_drv = 1'b1;
    logic up_oe, dn_oe, done, is_master;
    logic [7:0] node_id, slave_cnt;
    logic up_in, dn_in;
    int cyc = 0;
    int checks = 0, errors = 0;

    assign up_in = up_drv & ~up_oe;
    assign dn_in = dn_drv & ~dn_oe;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    enn_node #(.CYC_PER_MS(CYC), .BAUD_DIV(DIV)) u_enn_node (
        .clk(clk), .rst(rst), .up_in(up_in), .dn_in(dn_in),
        .up_oe(up_oe), .dn_oe(dn_oe), .done(done), .is_master(is_master),
        .node_id(node_id), .slave_cnt(slave_cnt));

    function automatic int exp_next(input int id);
        return (id + 1) % 256;
    endfunction

    function automatic int exp_count(input int k);
        return (k > 255) ? 255 : k;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; up_drv = 1'b1; dn_drv = 1'b1;
        repeat (3) @(negedge clk);
        chk(!up_oe && !dn_oe && !done && !is_master && node_id == 0 && slave_cnt == 0,
            "R1 reset outputs", {up_oe, dn_oe, done, is_master}, 0);
        rst = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        up_drv = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            up_drv = b[i];
            repeat (DIV) @(negedge clk);
        end
        up_drv = 1'b1;
        repeat (DIV) @(negedge clk);
    endtask

    task automatic wait_dn(output int t);
        for (int n = 0; n < 3000 && dn_oe !== 1'b1; n++) @(negedge clk);
        t = cyc;
    endtask

    task automatic measure_dn(output int len, output int t);
        wait_dn(t);
        len = 0;
        while (dn_oe === 1'b1 && len < 5000) begin len++; @(negedge clk); end
    endtask

    task automatic rx_byte(output logic [7:0] b);
        int t;
        wait_dn(t);
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(negedge clk);
            b[i] = ~dn_oe;
        end
        repeat (DIV) @(negedge clk);
    endtask

    task automatic wake_node();
        @(negedge clk);
        up_drv = 1'b0;
        repeat (20) @(negedge clk);
        up_drv = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wait_done(output int t);
        for (int n = 0; n < 12000 && done !== 1'b1; n++) @(negedge clk);
        t = cyc;
    endtask

    task automatic run_slave(input logic [7:0] id);
        int len, t, t_rel, t_done;
        logic [7:0] b;
        do_reset();
        wake_node();
        send_byte(8'h55);
        send_byte(8'h7E);
        send_byte(id);
        measure_dn(len, t);
        chk(len == WAKE_C, "R4 slave wake length", len, WAKE_C);
        rx_byte(b);
        chk(b == 8'h7E, "R5 slave sync byte", b, 8'h7E);
        rx_byte(b);
        chk(b == exp_next(id), "R5 slave next id", b, exp_next(id));
        for (int n = 0; n < 2000 && up_oe !== 1'b1; n++) @(negedge clk);
        len = 0;
        while (up_oe === 1'b1 && len < 5000) begin len++; @(negedge clk); end
        t_rel = cyc;
        chk(len == WAKE_C, "R6 announce length", len, WAKE_C);
        repeat (40) @(negedge clk);
        dn_drv = 1'b0;
        repeat (2) @(negedge clk);
        chk(up_oe === 1'b1, "R7 relay mirrors low", up_oe, 1);
        repeat (2) @(negedge clk);
        dn_drv = 1'b1;
        repeat (2) @(negedge clk);
        chk(up_oe === 1'b0, "R7 relay releases", up_oe, 0);
        wait_done(t_done);
        len = t_done - t_rel;
        chk(len >= RELAY_C - 2 && len <= RELAY_C + 2, "R7 relay duration", len, RELAY_C);
        chk(!is_master && node_id == id, "R2 slave role and id", node_id, id);
        chk(slave_cnt == 0, "R9 slave count zero", slave_cnt, 0);
        dn_drv = 1'b0;
        repeat (4) @(negedge clk);
        chk(up_oe === 1'b0 && done, "R9 no relay after done", up_oe, 0);
        dn_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_master(input int k);
        int len, t0, t, t_done;
        logic [7:0] b;
        do_reset();
        @(negedge clk);
        t0 = cyc;
        wake_node();
        send_byte(8'h41);
        measure_dn(len, t);
        chk(t - t0 >= LIST_C && t - t0 <= LIST_C + 8, "R3 listen timeout", t - t0, LIST_C);
        chk(len == WAKE_C, "R4 master wake length", len, WAKE_C);
        rx_byte(b);
        chk(b == 8'h7E, "R5 master sync byte", b, 8'h7E);
        rx_byte(b);
        chk(b == exp_next(0), "R5 master next id", b, exp_next(0));
        repeat (10) @(negedge clk);
        for (int i = 0; i < k; i++) begin
            dn_drv = 1'b0; repeat (2) @(negedge clk);
            dn_drv = 1'b1; repeat (2) @(negedge clk);
        end
        wait_done(t_done);
        chk(is_master && node_id == 0, "R3 master role and id", node_id, 0);
        chk(slave_cnt == exp_count(k), "R8 slave count", slave_cnt, exp_count(k));
        dn_drv = 1'b0; repeat (3) @(negedge clk);
        dn_drv = 1'b1; repeat (3) @(negedge clk);
        chk(slave_cnt == exp_count(k), "R9 count frozen after done", slave_cnt, exp_count(k));
    endtask

    initial begin
        int bad;
        void'($urandom(32'd2024));
        do_reset();
        bad = 0;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (up_oe || dn_oe || done) bad++;
        end
        chk(bad == 0, "R1 idle while upstream high", bad, 0);
        for (int i = 0; i < 3; i++) run_slave(8'($urandom_range(0, 254)));
        run_slave(8'hFF);
        run_master(int'($urandom_range(1, 20)));
        run_master(0);
        run_master(300);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule